// File: doc/BRIEF.md
# Transmit Word Supplier with Vector Latch

This block sits on the subsystem side of a serial-bus remote terminal. It supplies the data words that the terminal sends in answer to transmit commands. When the terminal pulls its request line low and the direction line shows a transmit, the block fetches the next word from a local store. The store is indexed by subaddress and word number. The block latches the word, answers with an active-low acknowledge, and then places the word on a shared 8-bit highway. The byte-select line picks the upper byte when high and the lower byte when low.

A separate vector path serves the transmit-vector mode command. User logic loads a 16-bit vector into a latch ahead of time. When the vector-enable line goes low, the latch is driven onto the highway by byte-select, with no acknowledge. A per-message word counter is cleared by the message-start pulse. It advances each time the terminal strobes the lower byte of a word away. User logic fills the word store through a simple write port. All inputs are taken as already synchronous to `clk`.

Top module: `txs_word_supplier`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ack_n` is 1, `hw_oe` is 0 and `hw_data` is 0.
- R2: With `dir_tx`=1, `req_n` falling causes `ack_n` to go low on the second clock edge after the edge that first samples the request. This is well inside a limit of `ACK_DEADLINE` cycles.
- R3: While `dir_tx`=0 a low `req_n` is ignored: `ack_n` stays 1 and `hw_oe` stays 0.
- R4: Once acknowledged and while `req_n` is low, `hw_oe` is 1. `hw_data` shows bits 15:8 of the word when `hbyte_sel`=1 and bits 7:0 when `hbyte_sel`=0. It follows `hbyte_sel` one clock edge later.
- R5: The edge after `req_n` returns high, `ack_n` is 1. If `vec_en_n` is also high, `hw_oe` is 0.
- R6: The word supplied is the store entry at address `subaddr * 2**IDX_W + word_index`. A write with `ld_en`=1 stores `ld_word` at `ld_sa * 2**IDX_W + ld_idx`.
- R7: `msg_start_n` low clears the word index to 0. The index advances by one, modulo 2**IDX_W, when `strobe` falls while the word is acknowledged, `req_n` is low and `hbyte_sel` is 0.
- R8: A word, once acknowledged, stays fixed on the highway even if its store entry is rewritten before `req_n` returns high.
- R9: While `vec_en_n` is low, `hw_oe` is 1 and `hw_data` shows the vector latch, upper byte for `hbyte_sel`=1 and lower byte for 0, with `ack_n` kept at 1. The vector takes priority over a pending word.
- R10: `vec_ld` loads `vec_word_in` into the vector latch only while `vec_en_n` is high. A load attempted while it is low has no effect.
- R11: Whenever both `req_n` and `vec_en_n` are high, `hw_oe` is 0 on the next edge and `hw_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low data request from the terminal |
| strobe | input | 1 | Byte strobe from the terminal |
| hbyte_sel | input | 1 | 1 selects upper byte, 0 lower byte |
| dir_tx | input | 1 | 1 for a transmit transfer |
| subaddr | input | SA_W | Subaddress of the current command |
| msg_start_n | input | 1 | Active-low message-start pulse |
| vec_en_n | input | 1 | Active-low vector enable |
| vec_ld | input | 1 | Load strobe for the vector latch |
| vec_word_in | input | WORD_W | Vector value to load |
| ld_en | input | 1 | Word store write enable |
| ld_sa | input | SA_W | Word store write subaddress |
| ld_idx | input | IDX_W | Word store write word number |
| ld_word | input | WORD_W | Word store write data |
| ack_n | output | 1 | Active-low acknowledge |
| hw_oe | output | 1 | Highway drive enable |
| hw_data | output | 8 | Highway byte |

## Verification
A corrupted control state shows first on `ack_n`. It appears as an acknowledge that never comes, one that comes for a receive transfer, or one that outlives the request. Each of these is visible within three cycles of the request edge. A wrong word index or store address shows as a wrong byte on the very next word served, and the bytes are compared against a model of the store. A wrong vector latch or a wrong drive enable shows on the edge after the enable changes.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CAPT = 2'd2,
    ST_ACK  = 2'd3
  } txs_state_e;
endpackage

// File: rtl/txs_word_store.sv
module txs_word_store #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/txs_word_ctrl.sv
module txs_word_ctrl
  import txs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SA_W   = 5,
  parameter int IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_n,
  input  logic                  strobe,
  input  logic                  hbyte_sel,
  input  logic                  dir_tx,
  input  logic [SA_W-1:0]       subaddr,
  input  logic                  msg_start_n,
  input  logic [WORD_W-1:0]     rd_data,
  output logic [SA_W+IDX_W-1:0] rd_addr,
  output logic [WORD_W-1:0]     word_buf,
  output logic                  word_valid,
  output logic                  ack_n,
  output logic [IDX_W-1:0]      word_idx
);
  txs_state_e state, nxt;
  logic       strobe_q;
  logic       low_taken;

  assign rd_addr    = {subaddr, word_idx};
  assign word_valid = (state == ST_ACK);
  assign low_taken  = word_valid && !req_n && !hbyte_sel && strobe_q && !strobe;

  always_comb begin
    nxt = state;
    if (req_n || !dir_tx) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: nxt = ST_READ;
        ST_READ: nxt = ST_CAPT;
        ST_CAPT: nxt = ST_ACK;
        ST_ACK:  nxt = ST_ACK;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_n    <= 1'b1;
      strobe_q <= 1'b0;
      word_buf <= '0;
      word_idx <= '0;
    end else begin
      state    <= nxt;
      ack_n    <= (nxt != ST_ACK);
      strobe_q <= strobe;
      if (state == ST_CAPT) word_buf <= rd_data;
      if (!msg_start_n)   word_idx <= '0;
      else if (low_taken) word_idx <= word_idx + 1'b1;
    end
  end
endmodule

// File: rtl/txs_vec_latch.sv
module txs_vec_latch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_ld,
  input  logic              vec_en_n,
  input  logic [WORD_W-1:0] vec_word_in,
  output logic [WORD_W-1:0] vec_word
);
  always_ff @(posedge clk) begin
    if (rst) vec_word <= '0;
    else if (vec_ld && vec_en_n) vec_word <= vec_word_in;
  end
endmodule

// File: rtl/txs_byte_mux.sv
module txs_byte_mux #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic              req_n,
  input  logic              dir_tx,
  input  logic              vec_en_n,
  input  logic              hbyte_sel,
  input  logic [WORD_W-1:0] word_buf,
  input  logic [WORD_W-1:0] vec_word,
  output logic              hw_oe,
  output logic [BYTE_W-1:0] hw_data
);
  logic [WORD_W-1:0] src;
  logic              drive;

  assign src   = !vec_en_n ? vec_word : word_buf;
  assign drive = !vec_en_n || (word_valid && !req_n && dir_tx);

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_oe   <= 1'b0;
      hw_data <= '0;
    end else begin
      hw_oe <= drive;
      if (!drive)        hw_data <= '0;
      else if (hbyte_sel) hw_data <= src[WORD_W-1 -: BYTE_W];
      else                hw_data <= src[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/txs_word_supplier.sv
module txs_word_supplier #(
  parameter int WORD_W       = 16,
  parameter int SA_W         = 5,
  parameter int IDX_W        = 5,
  parameter int ACK_DEADLINE = 81
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_n,
  input  logic              strobe,
  input  logic              hbyte_sel,
  input  logic              dir_tx,
  input  logic [SA_W-1:0]   subaddr,
  input  logic              msg_start_n,
  input  logic              vec_en_n,
  input  logic              vec_ld,
  input  logic [WORD_W-1:0] vec_word_in,
  input  logic              ld_en,
  input  logic [SA_W-1:0]   ld_sa,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_word,
  output logic              ack_n,
  output logic              hw_oe,
  output logic [7:0]        hw_data
);
  localparam int ADDR_W = SA_W + IDX_W;
  localparam int BYTE_W = 8;

  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] word_buf;
  logic [WORD_W-1:0] vec_word;
  logic              word_valid;
  logic [IDX_W-1:0]  word_idx;

  txs_word_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(ld_en), .wr_addr({ld_sa, ld_idx}), .wr_data(ld_word),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  txs_word_ctrl #(.WORD_W(WORD_W), .SA_W(SA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_n(req_n), .strobe(strobe), .hbyte_sel(hbyte_sel),
    .dir_tx(dir_tx), .subaddr(subaddr), .msg_start_n(msg_start_n),
    .rd_data(rd_data), .rd_addr(rd_addr), .word_buf(word_buf),
    .word_valid(word_valid), .ack_n(ack_n), .word_idx(word_idx)
  );

  txs_vec_latch #(.WORD_W(WORD_W)) u_vec (
    .clk(clk), .rst(rst), .vec_ld(vec_ld), .vec_en_n(vec_en_n),
    .vec_word_in(vec_word_in), .vec_word(vec_word)
  );

  txs_byte_mux #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mux (
    .clk(clk), .rst(rst), .word_valid(word_valid), .req_n(req_n),
    .dir_tx(dir_tx), .vec_en_n(vec_en_n), .hbyte_sel(hbyte_sel),
    .word_buf(word_buf), .vec_word(vec_word), .hw_oe(hw_oe), .hw_data(hw_data)
  );
endmodule

// File: rtl/txs_word_supplier_chk.sv
module txs_word_supplier_chk #(
  parameter int IDX_W        = 5,
  parameter int ACK_DEADLINE = 81
) (
  input logic             clk,
  input logic             rst,
  input logic             req_n,
  input logic             dir_tx,
  input logic             vec_en_n,
  input logic             msg_start_n,
  input logic             ack_n,
  input logic             hw_oe,
  input logic [IDX_W-1:0] word_idx
);
  localparam int WAIT_W = $clog2(ACK_DEADLINE + 1) + 1;
  logic [WAIT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) wait_cnt <= '0;
    else if (!req_n && dir_tx && ack_n) wait_cnt <= wait_cnt + 1'b1;
    else wait_cnt <= '0;
  end

  AST_ACK_DEADLINE: assert property (@(posedge clk) disable iff (rst)
    wait_cnt < WAIT_W'(ACK_DEADLINE)); // R2

  AST_ACK_ONLY_TX: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> $past(!req_n && dir_tx)); // R3

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    req_n |=> ack_n); // R5

  AST_VEC_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (!vec_en_n && req_n) |=> ack_n); // R9

  AST_VEC_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !vec_en_n |=> hw_oe); // R9

  AST_IDLE_TRISTATE: assert property (@(posedge clk) disable iff (rst)
    (req_n && vec_en_n) |=> !hw_oe); // R11

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !msg_start_n |=> (word_idx == '0)); // R7
endmodule

bind txs_word_supplier txs_word_supplier_chk #(
  .IDX_W(IDX_W), .ACK_DEADLINE(ACK_DEADLINE)
) u_chk (
  .clk(clk), .rst(rst), .req_n(req_n), .dir_tx(dir_tx), .vec_en_n(vec_en_n),
  .msg_start_n(msg_start_n), .ack_n(ack_n), .hw_oe(hw_oe), .word_idx(word_idx)
);

// File: tb/txs_word_supplier_tb.sv
module txs_word_supplier_tb;
  localparam int WORD_W = 16;
  localparam int SA_W   = 5;
  localparam int IDX_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b1, strobe = 1'b0, hbyte_sel = 1'b1, dir_tx = 1'b0;
  logic [SA_W-1:0] subaddr = '0;
  logic msg_start_n = 1'b1, vec_en_n = 1'b1, vec_ld = 1'b0;
  logic [WORD_W-1:0] vec_word_in = '0;
  logic ld_en = 1'b0;
  logic [SA_W-1:0] ld_sa = '0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [WORD_W-1:0] ld_word = '0;
  logic ack_n, hw_oe;
  logic [7:0] hw_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  txs_word_supplier u_dut (
    .clk(clk), .rst(rst), .req_n(req_n), .strobe(strobe), .hbyte_sel(hbyte_sel),
    .dir_tx(dir_tx), .subaddr(subaddr), .msg_start_n(msg_start_n),
    .vec_en_n(vec_en_n), .vec_ld(vec_ld), .vec_word_in(vec_word_in),
    .ld_en(ld_en), .ld_sa(ld_sa), .ld_idx(ld_idx), .ld_word(ld_word),
    .ack_n(ack_n), .hw_oe(hw_oe), .hw_data(hw_data)
  );

  function automatic logic [15:0] pat(input int sa, input int idx);
    return 16'h5A00 ^ 16'((sa << 10) | (idx << 5) | ((sa + idx) & 31));
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int sa, input int idx, input logic [15:0] w);
    ld_en = 1'b1; ld_sa = SA_W'(sa); ld_idx = IDX_W'(idx); ld_word = w;
    step();
    ld_en = 1'b0;
  endtask

  task automatic msg_start();
    msg_start_n = 1'b0; step(); msg_start_n = 1'b1;
  endtask

  // One full word transfer; checks latency, both bytes, release.
  task automatic word_xfer(input logic [15:0] exp, input string req);
    req_n = 1'b0; dir_tx = 1'b1; hbyte_sel = 1'b1;
    step(); chk("R2 ack after 1 edge", ack_n, 1);
    step(); chk("R2 ack after 2 edges", ack_n, 1);
    step(); chk("R2 ack after 3 edges", ack_n, 0);
    step(); chk({req, " hi oe"}, hw_oe, 1);
    chk({req, " hi byte"}, hw_data, exp[15:8]);
    strobe = 1'b1; step(); strobe = 1'b0; step();
    hbyte_sel = 1'b0; step();
    chk({req, " lo byte"}, hw_data, exp[7:0]);
    strobe = 1'b1; step(); strobe = 1'b0; step();
    req_n = 1'b1; hbyte_sel = 1'b1; step();
    chk("R5 ack released", ack_n, 1);
    chk("R11 oe off", hw_oe, 0);
    chk("R11 data zero", hw_data, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    chk("R1 ack_n", ack_n, 1); chk("R1 hw_oe", hw_oe, 0); chk("R1 hw_data", hw_data, 0);
    rst = 1'b0; step();
    chk("R1 ack_n after", ack_n, 1); chk("R1 hw_oe after", hw_oe, 0);
  endtask

  task automatic t_sequence();
    for (int i = 0; i < 4; i++) load(3, i, pat(3, i));
    for (int i = 0; i < 2; i++) load(7, i, pat(7, i));
    subaddr = 5'd3; msg_start();
    for (int i = 0; i < 4; i++) word_xfer(pat(3, i), "R4 R6 R7 sa3");
    subaddr = 5'd7; msg_start();
    word_xfer(pat(7, 0), "R7 restart sa7");
    word_xfer(pat(7, 1), "R6 sa7 word1");
  endtask

  task automatic t_receive_ignored();
    dir_tx = 1'b0; req_n = 1'b0;
    for (int i = 0; i < 6; i++) step();
    chk("R3 no ack on receive", ack_n, 1);
    chk("R3 no drive on receive", hw_oe, 0);
    req_n = 1'b1; step();
  endtask

  task automatic t_hold();
    load(9, 0, 16'h1234);
    subaddr = 5'd9; msg_start();
    req_n = 1'b0; dir_tx = 1'b1; hbyte_sel = 1'b1;
    for (int i = 0; i < 4; i++) step();
    load(9, 0, 16'hFEDC);
    step();
    chk("R8 hi stable", hw_data, 8'h12);
    hbyte_sel = 1'b0; step();
    chk("R8 lo stable", hw_data, 8'h34);
    req_n = 1'b1; hbyte_sel = 1'b1; step();
  endtask

  task automatic t_vector();
    vec_word_in = 16'hC3A5; vec_ld = 1'b1; step(); vec_ld = 1'b0;
    vec_en_n = 1'b0; hbyte_sel = 1'b1; step();
    chk("R9 vec oe", hw_oe, 1);
    chk("R9 vec hi", hw_data, 8'hC3);
    hbyte_sel = 1'b0; step();
    chk("R9 vec lo", hw_data, 8'hA5);
    vec_word_in = 16'h0F0F; vec_ld = 1'b1; step(); vec_ld = 1'b0; step();
    chk("R10 load ignored", hw_data, 8'hA5);
    hbyte_sel = 1'b1; step();
    chk("R10 hi kept", hw_data, 8'hC3);
    chk("R9 no ack", ack_n, 1);
    vec_en_n = 1'b1; step();
    chk("R11 vec released", hw_oe, 0);
    vec_ld = 1'b1; step(); vec_ld = 1'b0;
    vec_en_n = 1'b0; step();
    chk("R10 load when idle", hw_data, 8'h0F);
    vec_en_n = 1'b1; step();
  endtask

  task automatic t_vec_priority();
    load(4, 0, 16'h7788);
    subaddr = 5'd4; msg_start();
    req_n = 1'b0; dir_tx = 1'b1; hbyte_sel = 1'b1;
    for (int i = 0; i < 4; i++) step();
    vec_en_n = 1'b0; step();
    chk("R9 vector priority", hw_data, 8'h0F);
    vec_en_n = 1'b1; step();
    chk("R4 word back", hw_data, 8'h77);
    req_n = 1'b1; step();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sequence();
        t_receive_ignored();
        t_hold();
        t_vector();
        t_vec_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule